// File: doc/BRIEF.md
# Electromechanical Counter Pulse Driver

This block drives an electromechanical tally counter from single energy quanta. Each positive or negative quantum arrives as a one-cycle strobe. The block turns it into one long active-low pulse. Positive quanta go to one pin and negative quanta go to the other. A prescaler divides the master clock by a programmable divider K to make a slow tick. Every pulse is held low for a fixed number of those ticks. This gives the pulse a fixed duration in divided-clock time: at a 4.096 MHz divided clock the default of 524288 ticks gives 128 ms, so the pulse rate tops out near 7.8 Hz.

A strobe that arrives while a pulse is on the pins is not lost. It goes into a small signed backlog. Strobes of opposite sign cancel in the backlog, so only the net count is emitted later. The block works only in counter mode, which means the counter-mode input is 1 and the stepper-mode input is 0. In any other mode both pins stay high and the backlog is emptied.

The controller has three states:
- `ST_IDLE`: both pins high.
- `ST_POS`: the positive pin is low.
- `ST_NEG`: the negative pin is low.

The transitions are:
- `ST_IDLE`→`ST_POS` when the backlog is positive.
- `ST_IDLE`→`ST_NEG` when the backlog is negative.
- `ST_POS`/`ST_NEG`→`ST_IDLE` on the tick that completes the width.
- Any state→`ST_IDLE` whenever the block is disabled.

Top module: `mech_pulse_fmt`

## Requirements
- R1: When `mode_mech` is 0 or `mode_step` is 1, both outputs are high from the next clock on, and the backlog is cleared, so strobes queued before or during that time never produce a pulse later.
- R2: A net positive backlog drives `pulse_pos_n` to 0 (active low) while `pulse_neg_n` stays 1.
- R3: A net negative backlog drives `pulse_neg_n` to 0 while `pulse_pos_n` stays 1.
- R4: A pulse stays low for exactly WIDTH_TICKS prescaler ticks. It ends on the clock edge of the last tick, so it lasts between (WIDTH_TICKS-1)·K+1 and WIDTH_TICKS·K clock cycles.
- R5: The prescaler issues one tick every K clock cycles, where K is `div_k`; a `div_k` of 0 behaves as 1.
- R6: A strobe received while a pulse is active is queued and issued after that pulse. Consecutive pulses are separated by exactly one cycle with both outputs high.
- R7: Positive and negative strobes cancel one for one in the backlog, including two strobes in the same cycle, so only the net count is pulsed.
- R8: The backlog saturates at ±(2^(PEND_W-1)-1). Strobes beyond that bound are dropped.
- R9: The two outputs are never low at the same time.
- R10: In the idle state, a strobe in cycle t pulls its output low after the second rising edge following it, which is two clock edges of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_mech | input | 1 | Counter-mode select (1 to enable) |
| mode_step | input | 1 | Stepper-mode select (must be 0 to enable) |
| div_k | input | DIV_W | Prescaler divider K (0 treated as 1) |
| ev_pos | input | 1 | One-cycle positive energy quantum strobe |
| ev_neg | input | 1 | One-cycle negative energy quantum strobe |
| pulse_pos_n | output | 1 | Active-low pulse for positive energy |
| pulse_neg_n | output | 1 | Active-low pulse for negative energy |

## Verification
The hardest condition to reach is a full backlog. This needs more strobes than the saturation bound to arrive during a single pulse, and then the cancelling and clearing rules must act on that stored count. The stimulus first starts one pulse with a large divider so the pulse spans many cycles. It then sends a burst of same-sign strobes into that window, or a mixed-sign burst, or it drops the mode mid-pulse. Finally it counts the falling edges that follow. A behavioural reference model runs alongside and is compared on every clock while the divider is changed between runs.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_POS  = 2'd1,
        ST_NEG  = 2'd2
    } fmt_state_e;
endpackage

// File: rtl/mpf_tick_gen.sv
module mpf_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_k,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last_v;

    always_comb begin
        last_v = (div_k == '0) ? '0 : div_k - DIV_W'(1);
        tick   = en && (cnt_q >= last_v);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (!en)   cnt_q <= '0;
        else if (tick)  cnt_q <= '0;
        else            cnt_q <= cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/mpf_pending.sv
module mpf_pending #(
    parameter int PEND_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     inc,
    input  logic                     dec,
    input  logic                     take_pos,
    input  logic                     take_neg,
    output logic signed [PEND_W-1:0] pend,
    output logic                     has_pos,
    output logic                     has_neg
);
    localparam int SW = PEND_W + 2;
    localparam logic signed [SW-1:0] HI = SW'(2 ** (PEND_W - 1) - 1);
    localparam logic signed [SW-1:0] LO = -HI;

    logic signed [PEND_W-1:0] pend_q;
    logic signed [SW-1:0]     ext_v, step_v, sum_v;
    logic signed [PEND_W-1:0] next_v;

    always_comb begin
        ext_v  = {{2{pend_q[PEND_W-1]}}, pend_q};
        step_v = '0;
        if (inc)      step_v = step_v + SW'(1);
        if (dec)      step_v = step_v - SW'(1);
        if (take_pos) step_v = step_v - SW'(1);
        if (take_neg) step_v = step_v + SW'(1);
        sum_v  = ext_v + step_v;
        if (sum_v > HI)      next_v = HI[PEND_W-1:0];
        else if (sum_v < LO) next_v = LO[PEND_W-1:0];
        else                 next_v = sum_v[PEND_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pend_q <= '0;
        else if (!en) pend_q <= '0;
        else          pend_q <= next_v;
    end

    assign pend    = pend_q;
    assign has_neg = pend_q[PEND_W-1];
    assign has_pos = !pend_q[PEND_W-1] && (pend_q != '0);
endmodule

// File: rtl/mpf_width_cnt.sv
module mpf_width_cnt #(
    parameter int WIDTH_TICKS = 524288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = (WIDTH_TICKS > 2) ? $clog2(WIDTH_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH_TICKS - 1);

    logic [CW-1:0] w_q;

    assign done = run && tick && (w_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              w_q <= '0;
        else if (!run || done)   w_q <= '0;
        else if (tick)           w_q <= w_q + CW'(1);
    end
endmodule

// File: rtl/mech_pulse_fmt.sv
module mech_pulse_fmt #(
    parameter int DIV_W       = 8,
    parameter int PEND_W      = 4,
    parameter int WIDTH_TICKS = 524288
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_mech,
    input  logic             mode_step,
    input  logic [DIV_W-1:0] div_k,
    input  logic             ev_pos,
    input  logic             ev_neg,
    output logic             pulse_pos_n,
    output logic             pulse_neg_n
);
    import mpf_pkg::*;

    fmt_state_e               state_q, state_d;
    logic                     en, tick, done, run;
    logic                     take_pos, take_neg, has_pos, has_neg;
    logic signed [PEND_W-1:0] pend;

    assign en  = mode_mech && !mode_step;
    assign run = en && (state_q != ST_IDLE);

    assign take_pos = en && (state_q == ST_IDLE) && has_pos;
    assign take_neg = en && (state_q == ST_IDLE) && has_neg;

    mpf_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(en), .div_k(div_k), .tick(tick)
    );

    mpf_pending #(.PEND_W(PEND_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .en(en), .inc(ev_pos), .dec(ev_neg),
        .take_pos(take_pos), .take_neg(take_neg),
        .pend(pend), .has_pos(has_pos), .has_neg(has_neg)
    );

    mpf_width_cnt #(.WIDTH_TICKS(WIDTH_TICKS)) u_width (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .done(done)
    );

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (has_pos)      state_d = ST_POS;
                    else if (has_neg) state_d = ST_NEG;
                end
                ST_POS:  if (done) state_d = ST_IDLE;
                ST_NEG:  if (done) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pulse_pos_n = 1'b1;
        pulse_neg_n = 1'b1;
        unique case (state_q)
            ST_POS:  pulse_pos_n = 1'b0;
            ST_NEG:  pulse_neg_n = 1'b0;
            default: ;
        endcase
    end
endmodule

// File: rtl/mpf_checker.sv
module mpf_checker #(
    parameter int PEND_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     mode_mech,
    input logic                     mode_step,
    input logic                     pulse_pos_n,
    input logic                     pulse_neg_n,
    input logic                     tick,
    input logic signed [PEND_W-1:0] pend
);
    localparam int MAXP = 2 ** (PEND_W - 1) - 1;
    logic en_c;
    assign en_c = mode_mech && !mode_step;

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_c |=> (pulse_pos_n && pulse_neg_n)); // R1
    AST_POS_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_pos_n) |-> ($past(pend) > 0)); // R2
    AST_NEG_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_neg_n) |-> ($past(pend) < 0)); // R3
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (en_c && !pulse_pos_n && !tick) |=> !pulse_pos_n); // R4
    AST_GAP_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_pos_n) |-> pulse_neg_n); // R6
    AST_PEND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pend) <= MAXP) && (int'(pend) >= -MAXP)); // R8
    AST_NOT_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_pos_n || pulse_neg_n)); // R9
endmodule

bind mech_pulse_fmt mpf_checker #(.PEND_W(PEND_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_mech(mode_mech), .mode_step(mode_step),
    .pulse_pos_n(pulse_pos_n), .pulse_neg_n(pulse_neg_n),
    .tick(tick), .pend(pend)
);

// File: tb/mech_pulse_fmt_tb.sv
module mech_pulse_fmt_tb;
    localparam int DIV_W = 4;
    localparam int PEND_W = 3;
    localparam int WT = 4;
    localparam int MAXP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_mech = 1'b1, mode_step = 1'b0;
    logic [DIV_W-1:0] div_k = 4'd1;
    logic ev_pos = 1'b0, ev_neg = 1'b0;
    logic pulse_pos_n, pulse_neg_n;

    int tests = 0, fails = 0, cycles = 0;
    int m_st = 0, m_w = 0, m_p = 0, m_tc = 0;
    int falls_p = 0, falls_n = 0, cur_w = 0, last_w = 0;
    logic prev_p = 1'b1, prev_n = 1'b1;

    always #5 clk = ~clk;

    mech_pulse_fmt #(.DIV_W(DIV_W), .PEND_W(PEND_W), .WIDTH_TICKS(WT)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_mech(mode_mech), .mode_step(mode_step),
        .div_k(div_k), .ev_pos(ev_pos), .ev_neg(ev_neg),
        .pulse_pos_n(pulse_pos_n), .pulse_neg_n(pulse_neg_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference: 0 idle, 1 positive pulse, 2 negative pulse
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_w = 0; m_p = 0; m_tc = 0;
        end else begin
            bit en, tk, tp, tn;
            int k, s;
            en = mode_mech && !mode_step;
            k  = (div_k == 0) ? 1 : int'(div_k);
            tk = en && (m_tc >= k - 1);
            tp = en && m_st == 0 && m_p > 0;
            tn = en && m_st == 0 && m_p < 0;
            s  = m_p + int'(ev_pos) - int'(ev_neg) - int'(tp) + int'(tn);
            if (s > MAXP) s = MAXP;
            if (s < -MAXP) s = -MAXP;
            if (!en) begin
                m_st = 0; m_w = 0; m_p = 0; m_tc = 0;
            end else begin
                if (tp) m_st = 1;
                else if (tn) m_st = 2;
                else if (m_st != 0 && tk) begin
                    if (m_w == WT - 1) begin m_st = 0; m_w = 0; end
                    else m_w++;
                end
                m_p  = s;
                m_tc = tk ? 0 : m_tc + 1;
            end
        end
    end

    // Per-cycle comparison and pulse measurement
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(pulse_pos_n == (m_st != 1) && pulse_neg_n == (m_st != 2),
                  "R2 R3 R4 R5 model", {pulse_pos_n, pulse_neg_n}, {m_st != 1, m_st != 2});
            if (!pulse_pos_n && !pulse_neg_n) check(0, "R9 both low", 0, 1);
            if (prev_p && !pulse_pos_n) falls_p++;
            if (prev_n && !pulse_neg_n) falls_n++;
            if (!pulse_pos_n) cur_w++;
            else if (!prev_p) begin last_w = cur_w; cur_w = 0; end
        end
        prev_p = pulse_pos_n;
        prev_n = pulse_neg_n;
        if (cycles > 100000) begin
            check(0, "watchdog", cycles, 100000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_ev(input bit p, input bit n);
        @(negedge clk);
        ev_pos = p; ev_neg = n;
        @(negedge clk);
        ev_pos = 1'b0; ev_neg = 1'b0;
    endtask

    task automatic clr;
        falls_p = 0; falls_n = 0; last_w = 0;
    endtask

    initial begin
        wait_cyc(3);
        check(pulse_pos_n && pulse_neg_n, "R1 reset idle", {pulse_pos_n, pulse_neg_n}, 3);
        @(negedge clk); rst_n = 1'b1;
        wait_cyc(2);

        // R10 latency and R2/R4 width with K=1
        clr();
        @(negedge clk); ev_pos = 1'b1;
        @(negedge clk); ev_pos = 1'b0;
        check(pulse_pos_n == 1'b1, "R10 not yet low", pulse_pos_n, 1);
        @(negedge clk);
        check(pulse_pos_n == 1'b0, "R10 low after two edges", pulse_pos_n, 0);
        wait_cyc(10);
        check(falls_p == 1 && falls_n == 0, "R2 one positive pulse", falls_p, 1);
        check(last_w == WT, "R4 width K=1", last_w, WT);

        // R3 negative
        clr(); pulse_ev(0, 1); wait_cyc(10);
        check(falls_n == 1 && falls_p == 0, "R3 one negative pulse", falls_n, 1);

        // R6 burst of three queued
        clr();
        pulse_ev(1, 0); pulse_ev(1, 0); pulse_ev(1, 0);
        wait_cyc(25);
        check(falls_p == 3, "R6 three queued pulses", falls_p, 3);

        // R7 same-cycle cancel
        clr(); pulse_ev(1, 1); wait_cyc(10);
        check(falls_p == 0 && falls_n == 0, "R7 same-cycle cancel", falls_p + falls_n, 0);

        // R5 K=3 width range, then R7 cancel inside a pulse
        div_k = 4'd3;
        clr(); pulse_ev(1, 0); wait_cyc(1);
        pulse_ev(1, 0); pulse_ev(1, 0); pulse_ev(0, 1); pulse_ev(0, 1);
        wait_cyc(40);
        check(last_w >= (WT - 1) * 3 + 1 && last_w <= WT * 3, "R5 width K=3", last_w, WT * 3);
        check(falls_p == 1 && falls_n == 0, "R7 net zero backlog", falls_p + falls_n, 1);

        // R8 saturation
        clr(); pulse_ev(1, 0); wait_cyc(1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); ev_pos = 1'b1;
        end
        @(negedge clk); ev_pos = 1'b0;
        wait_cyc(80);
        check(falls_p == 1 + MAXP, "R8 saturated backlog", falls_p, 1 + MAXP);

        // R5 K=0 behaves as K=1
        div_k = 4'd0;
        clr(); pulse_ev(1, 0); wait_cyc(10);
        check(last_w == WT, "R5 width K=0", last_w, WT);

        // R1 disabled modes ignore strobes
        div_k = 4'd1;
        mode_mech = 1'b0;
        clr(); pulse_ev(1, 0); pulse_ev(0, 1); wait_cyc(3);
        mode_mech = 1'b1; wait_cyc(10);
        check(falls_p == 0 && falls_n == 0, "R1 mech off ignored", falls_p + falls_n, 0);
        mode_step = 1'b1;
        clr(); pulse_ev(1, 0); wait_cyc(3);
        mode_step = 1'b0; wait_cyc(10);
        check(falls_p == 0, "R1 stepper set ignored", falls_p, 0);

        // R1 disable mid-pulse clears backlog
        clr(); pulse_ev(1, 0); wait_cyc(1);
        pulse_ev(1, 0); pulse_ev(1, 0);
        mode_mech = 1'b0;
        @(negedge clk);
        check(pulse_pos_n && pulse_neg_n, "R1 off releases pins", {pulse_pos_n, pulse_neg_n}, 3);
        mode_mech = 1'b1;
        clr(); wait_cyc(20);
        check(falls_p == 0, "R1 backlog cleared", falls_p, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule